// File: doc/BRIEF.md
# Masked Lane Pack/Unpack Unit

This block moves 32-bit elements of a 512-bit vector between packed and sparse layouts under a 16-bit lane mask. In unpack (expand) mode the lowest source elements, starting at element 0, are placed in order into the lanes whose mask bit is set. In pack (compress) mode the selected lanes are collected, in ascending lane order, into consecutive low result positions. Every result position that receives no element either keeps the value of the old destination vector (merge) or becomes zero (zero fill).

A side input forces the mask to all ones, for the case where no mask is applied. Operands enter through a valid/ready handshake. The result is registered and is presented together with the number of active lanes. The output register holds its contents under backpressure, and the input is refused while it holds.

Top module: `lane_pack_unit`

## Requirements
- R1: With op_compress=0, result lane i (bits 32i+31:32i) equals source element k when mask bit i is 1, where k is the number of set mask bits below lane i.
- R2: With op_compress=1, result position k equals source lane i, where i is the lane of the (k+1)-th lowest set mask bit.
- R3: With zero_fill=0, every result position that receives no element equals the same lane of dst_old.
- R4: With zero_fill=1, every result position that receives no element is zero.
- R5: With no_mask=1, the effective mask is all ones and lane_mask is ignored.
- R6: out_count equals the number of set bits in the effective mask (0 to 16).
- R7: An input accepted on a clock edge (in_valid=1 and in_ready=1) appears with out_valid=1 immediately after that same edge.
- R8: While out_valid=1 and out_ready=0, in_ready is 0, and out_vec and out_count stay unchanged.
- R9: In compress mode, positions at or above out_count follow the fill rule of R3 or R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are presented |
| in_ready | output | 1 | Unit can take operands |
| op_compress | input | 1 | 1 = compress, 0 = expand |
| no_mask | input | 1 | 1 = treat every lane as active |
| zero_fill | input | 1 | 1 = clear unfilled positions, 0 = merge |
| lane_mask | input | 16 | Per-lane select, bit i is lane i |
| src_vec | input | 512 | Source vector, lane i at bits 32i+31:32i |
| dst_old | input | 512 | Prior destination vector used for merging |
| out_valid | output | 1 | Result is held |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | 512 | Result vector |
| out_count | output | 5 | Number of active lanes |

## Verification
Both the result vector and the count are due one edge after acceptance. The bench drives inputs at the falling edge, lets the next rising edge accept them, and reads out_valid, out_vec and out_count at the falling edge that follows. For backpressure, the bench holds out_ready low for several edges while a second operand waits at the input. At each falling edge it checks that in_ready is low and that the held result is unchanged. It then releases out_ready and expects the waiting operand one edge later.

// File: rtl/lane_pack_pkg.sv
package lane_pack_pkg;
  parameter int LP_LANES = 16;
  parameter int LP_EW    = 32;
endpackage

// File: rtl/lp_prefix.sv
// Exclusive prefix population count of a lane mask.
module lp_prefix #(
  parameter int LANES = 16,
  parameter int CW    = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]          mask,
  output logic [LANES-1:0][CW-1:0]  below,
  output logic [CW-1:0]             total
);
  always_comb begin
    logic [CW-1:0] run;
    run = '0;
    for (int i = 0; i < LANES; i++) begin
      below[i] = run;
      run      = run + CW'(mask[i]);
    end
    total = run;
  end
endmodule

// File: rtl/lp_expand.sv
// Scatter packed source elements into the selected lanes.
module lp_expand #(
  parameter int LANES = 16,
  parameter int EW    = 32,
  parameter int CW    = $clog2(LANES + 1),
  localparam int IW   = $clog2(LANES)
) (
  input  logic [LANES-1:0]          mask,
  input  logic [LANES-1:0][CW-1:0]  below,
  input  logic [LANES-1:0][EW-1:0]  src,
  input  logic [LANES-1:0][EW-1:0]  fill,
  output logic [LANES-1:0][EW-1:0]  res
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IW-1:0] idx;
    assign idx    = below[g][IW-1:0];
    assign res[g] = mask[g] ? src[idx] : fill[g];
  end
endmodule

// File: rtl/lp_compress.sv
// Gather the selected lanes into consecutive low positions.
module lp_compress #(
  parameter int LANES = 16,
  parameter int EW    = 32,
  parameter int CW    = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]          mask,
  input  logic [LANES-1:0][CW-1:0]  below,
  input  logic [LANES-1:0][EW-1:0]  src,
  input  logic [LANES-1:0][EW-1:0]  fill,
  output logic [LANES-1:0][EW-1:0]  res
);
  for (genvar j = 0; j < LANES; j++) begin : g_pos
    always_comb begin
      res[j] = fill[j];
      for (int i = j; i < LANES; i++) begin
        if (mask[i] && below[i] == CW'(j)) res[j] = src[i];
      end
    end
  end
endmodule

// File: rtl/lane_pack_unit.sv
module lane_pack_unit
  import lane_pack_pkg::*;
#(
  parameter int LANES = LP_LANES,
  parameter int EW    = LP_EW,
  localparam int VW   = LANES * EW,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             op_compress,
  input  logic             no_mask,
  input  logic             zero_fill,
  input  logic [LANES-1:0] lane_mask,
  input  logic [VW-1:0]    src_vec,
  input  logic [VW-1:0]    dst_old,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VW-1:0]    out_vec,
  output logic [CW-1:0]    out_count
);
  logic [LANES-1:0]          eff_mask;
  logic [LANES-1:0][EW-1:0]  src_l, dst_l, fill_l, exp_l, cmp_l;
  logic [LANES-1:0][CW-1:0]  below;
  logic [CW-1:0]             total;
  logic                      take;
  logic                      vld_d;
  logic [VW-1:0]             vec_d;
  logic [CW-1:0]             cnt_d;
  logic                      load_en;

  assign eff_mask = no_mask ? '1 : lane_mask;
  assign src_l    = src_vec;
  assign dst_l    = dst_old;

  for (genvar g = 0; g < LANES; g++) begin : g_fill
    assign fill_l[g] = zero_fill ? '0 : dst_l[g];
  end

  lp_prefix #(.LANES(LANES), .CW(CW)) u_pre (
    .mask(eff_mask), .below(below), .total(total)
  );

  lp_expand #(.LANES(LANES), .EW(EW), .CW(CW)) u_exp (
    .mask(eff_mask), .below(below), .src(src_l), .fill(fill_l), .res(exp_l)
  );

  lp_compress #(.LANES(LANES), .EW(EW), .CW(CW)) u_cmp (
    .mask(eff_mask), .below(below), .src(src_l), .fill(fill_l), .res(cmp_l)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_comb begin
    load_en = take;
    vec_d   = op_compress ? VW'(cmp_l) : VW'(exp_l);
    cnt_d   = total;
    if (take)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
    else                vld_d = out_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vec   <= '0;
      out_count <= '0;
    end else if (load_en) begin
      out_vec   <= vec_d;
      out_count <= cnt_d;
    end
  end
endmodule

// File: rtl/lp_checker.sv
module lp_checker #(
  parameter int LANES = 16,
  parameter int EW    = 32,
  localparam int VW   = LANES * EW,
  localparam int CW   = $clog2(LANES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             op_compress,
  input logic             no_mask,
  input logic             zero_fill,
  input logic [LANES-1:0] lane_mask,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VW-1:0]    out_vec,
  input logic [CW-1:0]    out_count
);
  p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vec) && $stable(out_count));

  p_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) && out_ready |=> !out_valid);

  p_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && no_mask |=> out_count == CW'(LANES));

  p_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_count == CW'($past($countones(no_mask ? {LANES{1'b1}} : lane_mask))));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && zero_fill && !no_mask && lane_mask == '0 |=> out_vec == '0);
endmodule

bind lane_pack_unit lp_checker #(.LANES(LANES), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op_compress(op_compress), .no_mask(no_mask), .zero_fill(zero_fill),
  .lane_mask(lane_mask), .out_valid(out_valid), .out_ready(out_ready),
  .out_vec(out_vec), .out_count(out_count)
);

// File: tb/sim_lane_pack_unit.sv
`timescale 1ns/1ps
module sim_lane_pack_unit;
  localparam int N  = 16;
  localparam int VW = 512;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, op_compress, no_mask, zero_fill;
  logic [N-1:0] lane_mask;
  logic [VW-1:0] src_vec, dst_old, out_vec;
  logic out_valid, out_ready;
  logic [4:0] out_count;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  lane_pack_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_compress(op_compress), .no_mask(no_mask), .zero_fill(zero_fill),
    .lane_mask(lane_mask), .src_vec(src_vec), .dst_old(dst_old),
    .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec),
    .out_count(out_count)
  );

  function automatic logic [VW-1:0] ref_vec(bit cmp, bit nm, bit zf,
      logic [N-1:0] m0, logic [VW-1:0] s, logic [VW-1:0] d);
    logic [VW-1:0] r;
    logic [N-1:0] m;
    int k;
    m = nm ? '1 : m0;
    k = 0;
    r = '0;
    if (!cmp) begin
      for (int i = 0; i < N; i++) begin
        if (m[i]) begin r[32*i +: 32] = s[32*k +: 32]; k++; end
        else r[32*i +: 32] = zf ? 32'h0 : d[32*i +: 32];
      end
    end else begin
      for (int i = 0; i < N; i++)
        if (m[i]) begin r[32*k +: 32] = s[32*i +: 32]; k++; end
      for (int j = k; j < N; j++) r[32*j +: 32] = zf ? 32'h0 : d[32*j +: 32];
    end
    return r;
  endfunction

  function automatic int ref_cnt(bit nm, logic [N-1:0] m);
    return nm ? N : $countones(m);
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < N; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, logic [VW-1:0] act, logic [VW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at falling edge, accept on next rising edge, check at following falling edge
  task automatic one_op(bit cmp, bit nm, bit zf, logic [N-1:0] m,
      logic [VW-1:0] s, logic [VW-1:0] d, string req);
    logic [VW-1:0] ev;
    int ec;
    @(negedge clk);
    op_compress = cmp; no_mask = nm; zero_fill = zf; lane_mask = m;
    src_vec = s; dst_old = d; in_valid = 1'b1; out_ready = 1'b1;
    ev = ref_vec(cmp, nm, zf, m, s, d);
    ec = ref_cnt(nm, m);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R7", "out_valid", VW'(out_valid), VW'(1));
    check(out_vec == ev, req, "out_vec", out_vec, ev);
    check(int'(out_count) == ec, "R6", "out_count", VW'(out_count), VW'(ec));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] s, d, held, ev;
    void'($urandom(32'd4711));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; op_compress = 1'b0;
    no_mask = 1'b0; zero_fill = 1'b0; lane_mask = '0; src_vec = '0; dst_old = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7", "reset out_valid", VW'(out_valid), VW'(0));
    check(in_ready == 1'b1, "R8", "reset in_ready", VW'(in_ready), VW'(1));
    rst_n = 1'b1;

    s = rnd_vec(); d = rnd_vec();
    one_op(0, 0, 0, 16'hA5A5, s, d, "R1");
    one_op(1, 0, 0, 16'hA5A5, s, d, "R2");
    one_op(0, 0, 0, 16'h0000, s, d, "R3");
    one_op(1, 0, 0, 16'h0001, s, d, "R9");
    one_op(1, 0, 1, 16'h8000, s, d, "R9");
    one_op(0, 0, 1, 16'h0000, s, d, "R4");
    one_op(1, 0, 1, 16'h0000, s, d, "R4");
    one_op(0, 1, 1, 16'h0000, s, d, "R5");
    one_op(1, 1, 0, 16'h1234, s, d, "R5");
    one_op(0, 0, 1, 16'hFFFF, s, d, "R1");
    one_op(1, 0, 0, 16'hF000, s, d, "R2");

    // backpressure: R8
    @(negedge clk);
    s = rnd_vec(); d = rnd_vec();
    op_compress = 1'b1; no_mask = 1'b0; zero_fill = 1'b0; lane_mask = 16'h0F0F;
    src_vec = s; dst_old = d; in_valid = 1'b1; out_ready = 1'b0;
    ev = ref_vec(1, 0, 0, 16'h0F0F, s, d);
    @(negedge clk);
    held = out_vec;
    check(out_vec == ev, "R2", "first item", out_vec, ev);
    lane_mask = 16'h00F0; op_compress = 1'b0; src_vec = rnd_vec();
    for (int c = 0; c < 4; c++) begin
      check(in_ready == 1'b0, "R8", "in_ready stalled", VW'(in_ready), VW'(0));
      check(out_vec == held && out_count == 5'd8, "R8", "held result", out_vec, held);
      @(negedge clk);
    end
    ev = ref_vec(0, 0, 0, 16'h00F0, src_vec, dst_old);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1 && out_vec == ev, "R8", "second item after stall", out_vec, ev);
    check(int'(out_count) == 4, "R6", "second count", VW'(out_count), VW'(4));
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "drained", VW'(out_valid), VW'(0));

    for (int t = 0; t < 300; t++) begin
      logic [N-1:0] m;
      m = N'($urandom);
      if (t % 7 == 0) m = '0;
      one_op(bit'($urandom & 1), bit'(($urandom % 9) == 0), bit'($urandom & 1),
             m, rnd_vec(), rnd_vec(), "R1/R2 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule